// File: doc/BRIEF.md
# Host interface power state controller

This block is the device-side keeper of the host interface protocol state. After a hardware reset it holds the link in a reset state in which the host may not touch the device registers. Once the device reports that its own initialisation is done, the block moves to a ready state in which the host may program registers. From there the host asks for the operational state (M0), and channel start commands are accepted only while it is held.

In M0 an inactivity timer watches the link. When the link stays quiet for a programmable number of cycles, the device suspends itself into M1. A further quiet period of the same length takes it into the low-power state M2. Any link activity in M1 or M2 brings it back to M0. Separately, the host can suspend operation into M3, and only a host wake request returns it from there.

A host request that names a state the current state cannot legally reach is ignored, and it sets an error flag that stays set until reset. The block drives the current state code and three permission outputs that the rest of the device uses to gate register access, channel start and power reduction.

Top module: `hostif_pwr_ctrl`

## Requirements
- R1: While reset is asserted and at the first sample after it, `pwr_state` is 0 (RESET), and `reg_access_en`, `chan_start_ok`, `low_power_ok` and `req_error` are all 0.
- R2: The state leaves RESET (0) for READY (1) on the first clock edge where `init_done` is sampled high, and stays in RESET otherwise. `reg_access_en` is 1 in every state except RESET.
- R3: A host request with code 2 (M0) sampled in READY (1) moves the state to M0 (2) at that edge.
- R4: `chan_start_ok` is 1 exactly while the state is M0 (2).
- R5: In M0, let N be `idle_limit`, or 1 when `idle_limit` is 0. After N consecutive sampled cycles with `link_active` low, the state becomes M1 (3) at the N-th edge. A cycle with `link_active` high restarts the count.
- R6: In M1, a further N consecutive quiet cycles move the state to M2 (4). `low_power_ok` is 1 exactly in M2 (4) and M3 (5).
- R7: `link_active` sampled high in M1 (3) or M2 (4) returns the state to M0 (2) at that edge.
- R8: Request code 5 (M3) is legal in M0, M1 and M2 and moves the state to M3 (5). In M3, `link_active` has no effect, and request code 2 returns the state to M0.
- R9: Every request not listed in R3 or R8 is illegal: it does not change the state, and it sets `req_error`, which stays 1 until reset. Illegal requests include requests made in RESET, requests that name the current state, and request codes 0, 1, 3, 4, 6 and 7.
- R10: A legal host request takes priority over a timer expiry or a link wake in the same cycle. An illegal request does not block those device events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, synchronous |
| init_done | input | 1 | Device initialisation finished |
| host_req_valid | input | 1 | Host state request strobe, one cycle per request |
| host_req_state | input | 3 | Requested state code (2 = M0, 5 = M3) |
| link_active | input | 1 | Link showed activity this cycle |
| idle_limit | input | TIMER_W | Number of quiet cycles before a suspend step |
| pwr_state | output | 3 | Current state: 0 RESET, 1 READY, 2 M0, 3 M1, 4 M2, 5 M3 |
| reg_access_en | output | 1 | Host register access allowed |
| chan_start_ok | output | 1 | Channel start commands allowed |
| low_power_ok | output | 1 | Device may reduce power |
| req_error | output | 1 | Sticky flag set by an illegal request |

## Verification
The bench builds the block with TIMER_W = 4, so every inactivity limit from 0 to 15 is swept, and each one is followed through M0, M1, M2 and a wake back to M0. The 3-bit request code makes it possible to apply all eight codes from each of the six states, which covers the whole legality table and the sticky error in 48 runs. Directed cases then cover the restart of the count on activity, the M3 state ignoring the link, and the same-cycle priority between host requests and device events.

// File: rtl/hostif_pwr_pkg.sv
package hostif_pwr_pkg;

  typedef enum logic [2:0] {
    PS_RESET = 3'd0,
    PS_READY = 3'd1,
    PS_M0    = 3'd2,
    PS_M1    = 3'd3,
    PS_M2    = 3'd4,
    PS_M3    = 3'd5
  } pstate_e;

  // Host-driven transitions permitted from a given state
  function automatic logic host_move_legal(pstate_e cur, logic [2:0] code);
    logic ok;
    ok = 1'b0;
    case (cur)
      PS_READY: ok = (code == PS_M0);
      PS_M0,
      PS_M1,
      PS_M2:    ok = (code == PS_M3);
      PS_M3:    ok = (code == PS_M0);
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic access_allowed(pstate_e cur);
    return cur != PS_RESET;
  endfunction

  function automatic logic chan_allowed(pstate_e cur);
    return cur == PS_M0;
  endfunction

  function automatic logic power_down_allowed(pstate_e cur);
    return (cur == PS_M2) || (cur == PS_M3);
  endfunction

  // States in which the inactivity timer runs
  function automatic logic idle_watched(pstate_e cur);
    return (cur == PS_M0) || (cur == PS_M1);
  endfunction

endpackage

// File: rtl/hostif_idle_timer.sv
module hostif_idle_timer #(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               count_en,
  input  logic               activity,
  input  logic               restart,
  input  logic [TIMER_W-1:0] limit,
  output logic               expire
);

  localparam int CW = TIMER_W + 1;

  logic [TIMER_W-1:0] cnt_q;

  // True when this quiet cycle is the last one of the window
  function automatic logic window_done(logic [TIMER_W-1:0] cnt,
                                       logic [TIMER_W-1:0] lim);
    logic [CW-1:0] seen;
    seen = {1'b0, cnt} + CW'(1);
    return seen >= {1'b0, lim};
  endfunction

  assign expire = count_en && !activity && window_done(cnt_q, limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!count_en || activity || restart || expire) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + TIMER_W'(1);
    end
  end

endmodule

// File: rtl/hostif_state_gate.sv
module hostif_state_gate
  import hostif_pwr_pkg::*;
(
  input  pstate_e    cur,
  input  logic [2:0] req_code,
  output logic       req_legal,
  output logic       count_en,
  output logic       reg_access_en,
  output logic       chan_start_ok,
  output logic       low_power_ok
);

  assign req_legal     = host_move_legal(cur, req_code);
  assign count_en      = idle_watched(cur);
  assign reg_access_en = access_allowed(cur);
  assign chan_start_ok = chan_allowed(cur);
  assign low_power_ok  = power_down_allowed(cur);

endmodule

// File: rtl/hostif_state_seq.sv
module hostif_state_seq
  import hostif_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_done,
  input  logic       req_valid,
  input  logic [2:0] req_code,
  input  logic       req_legal,
  input  logic       idle_expire,
  input  logic       link_active,
  output pstate_e    cur,
  output logic       moving,
  output logic       err_flag
);

  pstate_e cur_q, nxt;
  logic    err_q;
  logic    host_go;

  assign host_go = req_valid && req_legal;

  always_comb begin
    nxt = cur_q;
    if (cur_q == PS_RESET) begin
      if (init_done) nxt = PS_READY;
    end else if (host_go) begin
      nxt = pstate_e'(req_code);
    end else begin
      case (cur_q)
        PS_M0: if (idle_expire) nxt = PS_M1;
        PS_M1: begin
          if (link_active)      nxt = PS_M0;
          else if (idle_expire) nxt = PS_M2;
        end
        PS_M2: if (link_active) nxt = PS_M0;
        default: nxt = cur_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= PS_RESET;
      err_q <= 1'b0;
    end else begin
      cur_q <= nxt;
      err_q <= err_q | (req_valid & ~req_legal);
    end
  end

  assign cur      = cur_q;
  assign moving   = (nxt != cur_q);
  assign err_flag = err_q;

endmodule

// File: rtl/hostif_pwr_ctrl.sv
module hostif_pwr_ctrl
  import hostif_pwr_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_done,
  input  logic               host_req_valid,
  input  logic [2:0]         host_req_state,
  input  logic               link_active,
  input  logic [TIMER_W-1:0] idle_limit,
  output logic [2:0]         pwr_state,
  output logic               reg_access_en,
  output logic               chan_start_ok,
  output logic               low_power_ok,
  output logic               req_error
);

  pstate_e cur;
  logic    req_legal;
  logic    count_en;
  logic    idle_expire;
  logic    moving;

  hostif_state_gate gate_i (
    .cur           (cur),
    .req_code      (host_req_state),
    .req_legal     (req_legal),
    .count_en      (count_en),
    .reg_access_en (reg_access_en),
    .chan_start_ok (chan_start_ok),
    .low_power_ok  (low_power_ok)
  );

  hostif_idle_timer #(.TIMER_W(TIMER_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (count_en),
    .activity (link_active),
    .restart  (moving),
    .limit    (idle_limit),
    .expire   (idle_expire)
  );

  hostif_state_seq seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_done   (init_done),
    .req_valid   (host_req_valid),
    .req_code    (host_req_state),
    .req_legal   (req_legal),
    .idle_expire (idle_expire),
    .link_active (link_active),
    .cur         (cur),
    .moving      (moving),
    .err_flag    (req_error)
  );

  assign pwr_state = cur;

endmodule

// File: rtl/hostif_pwr_ctrl_chk.sv
module hostif_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_done,
  input logic       host_req_valid,
  input logic       link_active,
  input logic [2:0] pwr_state,
  input logic       reg_access_en,
  input logic       req_error,
  input logic       req_legal,
  input logic       idle_expire
);

  // R1
  reset_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd0) |-> !reg_access_en);

  // R2
  hold_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd0 && !init_done) |=> (pwr_state == 3'd0));

  // R5
  idle_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd2 && idle_expire && !(host_req_valid && req_legal))
    |=> (pwr_state == 3'd3));

  // R7
  link_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_state == 3'd3 || pwr_state == 3'd4) && link_active && !host_req_valid)
    |=> (pwr_state == 3'd2));

  // R8
  host_only_m3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd5 && !host_req_valid) |=> (pwr_state == 3'd5));

  // R9
  bad_req_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req_valid && !req_legal) |=> req_error);

  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_error |=> req_error);

endmodule

bind hostif_pwr_ctrl hostif_pwr_ctrl_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .init_done      (init_done),
  .host_req_valid (host_req_valid),
  .link_active    (link_active),
  .pwr_state      (pwr_state),
  .reg_access_en  (reg_access_en),
  .req_error      (req_error),
  .req_legal      (req_legal),
  .idle_expire    (idle_expire)
);

// File: tb/hostif_pwr_ctrl_tb_top.sv
module hostif_pwr_ctrl_tb_top;

  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          init_done;
  logic          host_req_valid;
  logic [2:0]    host_req_state;
  logic          link_active;
  logic [TW-1:0] idle_limit;
  logic [2:0]    pwr_state;
  logic          reg_access_en, chan_start_ok, low_power_ok, req_error;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hostif_pwr_ctrl #(.TIMER_W(TW)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .init_done      (init_done),
    .host_req_valid (host_req_valid),
    .host_req_state (host_req_state),
    .link_active    (link_active),
    .idle_limit     (idle_limit),
    .pwr_state      (pwr_state),
    .reg_access_en  (reg_access_en),
    .chan_start_ok  (chan_start_ok),
    .low_power_ok   (low_power_ok),
    .req_error      (req_error)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    init_done = 0; host_req_valid = 0; host_req_state = 0; link_active = 0;
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic pulse_init();
    init_done = 1; tick(); init_done = 0;
  endtask

  task automatic send_req(input int code);
    host_req_valid = 1; host_req_state = 3'(code);
    tick();
    host_req_valid = 0; host_req_state = 0;
  endtask

  task automatic goto_state(input int s, input int lim);
    idle_limit = TW'(lim);
    do_reset();
    if (s >= 1) pulse_init();
    if (s >= 2) send_req(2);
    if (s == 3) repeat (lim) tick();
    if (s == 4) repeat (2 * lim) tick();
    if (s == 5) send_req(5);
  endtask

  function automatic bit legal_pair(input int s, input int c);
    if (s == 1 && c == 2) return 1;
    if (c == 5 && s >= 2 && s <= 4) return 1;
    if (s == 5 && c == 2) return 1;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_limit = TW'(8);
    rst_n = 0;
    do_reset();
    // R1: reset values
    chk(pwr_state == 0, "R1 state", pwr_state, 0);
    chk(!reg_access_en, "R1 reg_access_en", reg_access_en, 0);
    chk(!chan_start_ok, "R1 chan_start_ok", chan_start_ok, 0);
    chk(!low_power_ok, "R1 low_power_ok", low_power_ok, 0);
    chk(!req_error, "R1 req_error", req_error, 0);

    // R2: stays in RESET without init_done, leaves on it
    repeat (5) tick();
    chk(pwr_state == 0, "R2 hold RESET", pwr_state, 0);
    pulse_init();
    chk(pwr_state == 1, "R2 to READY", pwr_state, 1);

    // Sweep every state against every request code (R2 R3 R4 R6 R8 R9)
    for (int s = 0; s < 6; s++) begin
      for (int c = 0; c < 8; c++) begin
        bit lg;
        int expd;
        goto_state(s, 8);
        chk(pwr_state == 3'(s), "R2 reach state", pwr_state, s);
        chk(reg_access_en == (s != 0), "R2 reg_access_en", reg_access_en, s != 0);
        chk(chan_start_ok == (s == 2), "R4 chan_start_ok", chan_start_ok, s == 2);
        chk(low_power_ok == (s == 4 || s == 5), "R6 low_power_ok", low_power_ok,
            s == 4 || s == 5);
        lg = legal_pair(s, c);
        expd = lg ? c : s;
        send_req(c);
        if (lg) chk(pwr_state == 3'(expd), "R3 R8 legal request", pwr_state, expd);
        else    chk(pwr_state == 3'(expd), "R9 ignored request", pwr_state, expd);
        chk(req_error == !lg, "R9 error flag", req_error, !lg);
      end
    end

    // Timer sweep over all limits (R5 R6 R7)
    for (int lim = 0; lim < 16; lim++) begin
      int n;
      n = (lim == 0) ? 1 : lim;
      goto_state(2, lim);
      repeat (n - 1) tick();
      chk(pwr_state == 2, "R5 still M0", pwr_state, 2);
      tick();
      chk(pwr_state == 3, "R5 enter M1", pwr_state, 3);
      repeat (n - 1) tick();
      chk(pwr_state == 3, "R6 still M1", pwr_state, 3);
      tick();
      chk(pwr_state == 4, "R6 enter M2", pwr_state, 4);
      link_active = 1; tick(); link_active = 0;
      chk(pwr_state == 2, "R7 wake from M2", pwr_state, 2);
    end

    // R5: activity restarts the count
    goto_state(2, 6);
    repeat (4) tick();
    link_active = 1; tick(); link_active = 0;
    repeat (5) tick();
    chk(pwr_state == 2, "R5 restart holds M0", pwr_state, 2);
    tick();
    chk(pwr_state == 3, "R5 restart then M1", pwr_state, 3);

    // R7: wake from M1
    goto_state(3, 4);
    link_active = 1; tick(); link_active = 0;
    chk(pwr_state == 2, "R7 wake from M1", pwr_state, 2);

    // R8: link activity has no effect in M3
    goto_state(5, 8);
    link_active = 1; repeat (20) tick(); link_active = 0;
    chk(pwr_state == 5, "R8 M3 ignores link", pwr_state, 5);
    send_req(2);
    chk(pwr_state == 2, "R8 host wake", pwr_state, 2);

    // R10: legal request beats link wake
    goto_state(3, 8);
    link_active = 1; send_req(5); link_active = 0;
    chk(pwr_state == 5, "R10 request over wake", pwr_state, 5);

    // R10: legal request beats timer expiry
    goto_state(2, 3);
    repeat (2) tick();
    send_req(5);
    chk(pwr_state == 5, "R10 request over expiry", pwr_state, 5);

    // R10: illegal request does not block a wake; R9 flag sticks
    goto_state(3, 8);
    link_active = 1; send_req(1); link_active = 0;
    chk(pwr_state == 2, "R10 wake despite bad request", pwr_state, 2);
    chk(req_error, "R9 flag set", req_error, 1);
    link_active = 1; repeat (10) tick();
    send_req(5);
    chk(req_error, "R9 flag sticky", req_error, 1);
    link_active = 0;
    do_reset();
    chk(!req_error, "R9 flag cleared by reset", req_error, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule